// File: doc/BRIEF.md
# Timer-Driven SPI Master

This block is an SPI master for clock modes 0 and 1 (SCK idles low). A host writes a transmit word through a simple write port. As soon as the word is held and the shift engine is idle, a frame starts on its own. A baud/bit timer makes SCK. A second, slaved timer holds the active-low chip select low for as long as the clock timer runs. When the frame ends, the word received on MISO sits in a read register, and a full flag announces it.

The clock timer runs from a 16-bit compare word. Its lower byte is the half-period divider, so SCK toggles every divider+1 input clocks. Its upper byte is the index of the last SCK edge, which is two times the frame bits minus one. Only the divider can be rewritten at run time. The edge index is set again from the width setting at every frame start. Frames are 8 or 16 bits wide and go MSB-first or LSB-first. A write can ask for a fixed dummy word in place of host data.

Top module: `spim_master`

## Requirements
- R1: After reset, cs_n=1, sck=0, mosi=0, tx_empty=1, rx_full=0, and the divider equals (CLK_HZ/BIT_RATE)/2-1, which is 9 with the defaults.
- R2: A write accepted while tx_empty=1 drops tx_empty in the next cycle. One cycle later the word moves into the shifter, tx_empty returns to 1 and cs_n falls. cfg_cpha, cfg_lsb and cfg_wide are sampled at that moment.
- R3: A frame has a start phase, 2×bits SCK edges and a stop phase, each D=divider+1 clocks apart. cs_n therefore stays low for exactly (2×bits+2)×D cycles.
- R4: A write on the divider port changes only the divider. The edge count still follows the frame width, so later 8-bit and 16-bit frames last 18×D and 34×D cycles.
- R5: With cfg_cpha=0, the first data bit is on mosi from the moment cs_n falls. mosi changes on falling SCK edges, and miso is sampled on rising edges.
- R6: With cfg_cpha=1, mosi stays low until the first rising edge and changes only on rising edges. It goes low again after the last edge, and miso is sampled on falling edges.
- R7: cfg_wide=1 selects 16-bit frames. cfg_wide=0 selects 8-bit frames that send wr_data[7:0] and return the received byte in rd_data[7:0] with rd_data[15:8]=0.
- R8: cfg_lsb=1 sends bit 0 first and also places the first received bit in bit 0 of rd_data. cfg_lsb=0 sends and receives the top bit of the frame first.
- R9: A write with wr_dummy=1 sends DUMMY_WORD (default 16'hA5C3, its lower byte in 8-bit frames) in place of wr_data.
- R10: rx_full rises in the same cycle that cs_n rises at the end of a frame, and rd_data then holds the received word. A cycle with rd_en=1 clears rx_full. A frame that completes while rx_full=1 overwrites rd_data.
- R11: A write while tx_empty=0 is dropped. The held word is kept and no extra frame results.
- R12: While cs_n=1, sck and mosi are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the transmit holding word |
| wr_data | input | 16 | Transmit word (lower byte used in 8-bit frames) |
| wr_dummy | input | 1 | Send the dummy word in place of wr_data |
| tx_empty | output | 1 | Holding word is free for a write |
| rd_en | input | 1 | Read strobe, clears rx_full |
| rd_data | output | 16 | Last received word |
| rx_full | output | 1 | A received word is waiting |
| cfg_cpha | input | 1 | Clock phase: 0 first-edge capture, 1 second-edge capture |
| cfg_lsb | input | 1 | 1 = LSB first |
| cfg_wide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| div_wr_en | input | 1 | Write strobe for the half-period divider |
| div_wr_data | input | 8 | New divider value |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check, on every cycle, the rules that hold across frames: SCK and MOSI stay quiet while the select is released, chip select falls only as the holding word empties, an accepted write marks the holding word full, and the receive flag rises only together with the release of the select and drops after a read. The bench scenarios cover what needs whole frames. A bench slave model checks the serial bit order on both phases and widths, the dummy substitution and the received word. The bench also measures the select-low time before and after a divider change, and shows that a write into a full holding word leaves no trace.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned NARROW_W = 8;

  typedef enum logic [1:0] {
    TM_IDLE  = 2'd0,
    TM_START = 2'd1,
    TM_RUN   = 2'd2,
    TM_STOP  = 2'd3
  } tmr_state_e;

  typedef struct packed {
    logic cpha;
    logic lsb;
    logic wide;
  } frame_cfg_t;

  // Zero-extend a narrow word and, if asked, mirror it within the frame width.
  function automatic logic [WORD_W-1:0] orient(input logic [WORD_W-1:0] v,
                                               input logic wide,
                                               input logic lsb);
    logic [WORD_W-1:0] r;
    logic [WORD_W-1:0] t;
    r = wide ? v : {{(WORD_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
    t = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (wide) t[i] = r[WORD_W-1-i];
      else if (i < int'(NARROW_W)) t[i] = r[NARROW_W-1-i];
    end
    return lsb ? t : r;
  endfunction

endpackage

// File: rtl/spim_baud_timer.sv
module spim_baud_timer
  import spim_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] div,
  input  logic [CNT_W-1:0] last_edge,
  output logic             sck,
  output logic             active,
  output logic             edge_ev,
  output logic             rise_ev,
  output logic             last_ev,
  output logic             done
);

  tmr_state_e       st_q, st_d;
  logic [CNT_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] edg_q, edg_d;
  logic             sck_q, sck_d;
  logic             tick;

  assign tick    = (pre_q == '0);
  assign edge_ev = (st_q == TM_RUN) && tick;
  assign rise_ev = edge_ev && !sck_q;
  assign last_ev = edge_ev && (edg_q == last_edge);
  assign done    = (st_q == TM_STOP) && tick;
  assign active  = (st_q != TM_IDLE);
  assign sck     = sck_q;

  always_comb begin
    st_d  = st_q;
    pre_d = pre_q;
    edg_d = edg_q;
    sck_d = sck_q;
    unique case (st_q)
      TM_IDLE: begin
        if (start) begin
          st_d  = TM_START;
          pre_d = div;
          edg_d = '0;
          sck_d = 1'b0;
        end
      end
      TM_START: begin
        if (tick) begin
          st_d  = TM_RUN;
          pre_d = div;
        end else begin
          pre_d = pre_q - 1'b1;
        end
      end
      TM_RUN: begin
        if (tick) begin
          sck_d = ~sck_q;
          edg_d = edg_q + 1'b1;
          pre_d = div;
          if (edg_q == last_edge) st_d = TM_STOP;
        end else begin
          pre_d = pre_q - 1'b1;
        end
      end
      TM_STOP: begin
        if (tick) st_d = TM_IDLE;
        else      pre_d = pre_q - 1'b1;
      end
      default: st_d = TM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TM_IDLE;
      pre_q <= '0;
      edg_q <= '0;
      sck_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pre_q <= pre_d;
      edg_q <= edg_d;
      sck_q <= sck_d;
    end
  end

endmodule

// File: rtl/spim_select_timer.sv
module spim_select_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic cs_n
);

  logic cs_n_q, cs_n_d;

  always_comb begin
    cs_n_d = cs_n_q;
    if (start)     cs_n_d = 1'b0;
    else if (done) cs_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= cs_n_d;
  end

  assign cs_n = cs_n_q;

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              cpha,
  input  logic              edge_ev,
  input  logic              rise_ev,
  input  logic              last_ev,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] txs_q, txs_d;
  logic [WORD_W-1:0] rxs_q, rxs_d;
  logic              primed_q, primed_d;
  logic              fall_ev, sample, shift_tx;

  assign fall_ev  = edge_ev && !rise_ev;
  assign sample   = cpha ? fall_ev : rise_ev;
  assign shift_tx = cpha ? (rise_ev && primed_q) : fall_ev;

  always_comb begin
    txs_d    = txs_q;
    rxs_d    = rxs_q;
    primed_d = primed_q;
    if (load)          txs_d = load_word;
    else if (shift_tx) txs_d = {txs_q[WORD_W-2:0], 1'b0};
    if (load)                   primed_d = 1'b0;
    else if (cpha && last_ev)   primed_d = 1'b0;
    else if (cpha && rise_ev)   primed_d = 1'b1;
    if (sample) rxs_d = {rxs_q[WORD_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs_q    <= '0;
      rxs_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      txs_q    <= txs_d;
      rxs_q    <= rxs_d;
      primed_q <= primed_d;
    end
  end

  assign mosi    = cpha ? (primed_q && txs_q[WORD_W-1]) : txs_q[WORD_W-1];
  assign rx_word = rxs_q;

endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int unsigned       CLK_HZ     = 10_000_000,
  parameter int unsigned       BIT_RATE   = 500_000,
  parameter logic [WORD_W-1:0] DUMMY_WORD = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_dummy,
  output logic              tx_empty,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_full,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb,
  input  logic              cfg_wide,
  input  logic              div_wr_en,
  input  logic [7:0]        div_wr_data,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  localparam int unsigned CMP_W   = 8;
  localparam logic [CMP_W-1:0] DIV_RST   = CMP_W'((CLK_HZ / BIT_RATE) / 2 - 1);
  localparam logic [CMP_W-1:0] EDGES_NAR = CMP_W'(2 * NARROW_W - 1);
  localparam logic [CMP_W-1:0] EDGES_WID = CMP_W'(2 * WORD_W - 1);

  logic [WORD_W-1:0] hold_q, hold_d;
  logic              empty_q, empty_d;
  logic [WORD_W-1:0] rdat_q, rdat_d;
  logic              full_q, full_d;
  logic [CMP_W-1:0]  div_q, div_d;
  logic [CMP_W-1:0]  edges_q, edges_d;
  frame_cfg_t        cfg_q, cfg_d;

  logic              t_active, t_edge, t_rise, t_last, t_done, go;
  logic [WORD_W-1:0] tx_oriented, load_word, rx_raw, rx_word;

  assign go = !t_active && !empty_q;

  // Write path: mirror with the settings of the frame being started, then left-justify.
  assign tx_oriented = orient(hold_q, cfg_wide, cfg_lsb);
  assign load_word   = cfg_wide ? tx_oriented
                                : {tx_oriented[NARROW_W-1:0], {(WORD_W-NARROW_W){1'b0}}};

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    if (go) begin
      empty_d = 1'b1;
    end else if (wr_en && empty_q) begin
      hold_d  = wr_dummy ? DUMMY_WORD : wr_data;
      empty_d = 1'b0;
    end
  end

  always_comb begin
    div_d   = div_wr_en ? div_wr_data : div_q;
    edges_d = go ? (cfg_wide ? EDGES_WID : EDGES_NAR) : edges_q;
    cfg_d   = go ? '{cpha: cfg_cpha, lsb: cfg_lsb, wide: cfg_wide} : cfg_q;
  end

  assign rx_word = orient(rx_raw, cfg_q.wide, cfg_q.lsb);

  always_comb begin
    rdat_d = rdat_q;
    full_d = full_q;
    if (t_done) begin
      rdat_d = rx_word;
      full_d = 1'b1;
    end else if (rd_en) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      rdat_q  <= '0;
      full_q  <= 1'b0;
      div_q   <= DIV_RST;
      edges_q <= EDGES_NAR;
      cfg_q   <= '0;
    end else begin
      hold_q  <= hold_d;
      empty_q <= empty_d;
      rdat_q  <= rdat_d;
      full_q  <= full_d;
      div_q   <= div_d;
      edges_q <= edges_d;
      cfg_q   <= cfg_d;
    end
  end

  spim_baud_timer #(.CNT_W(CMP_W)) i_clk_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .div       (div_q),
    .last_edge (edges_q),
    .sck       (sck),
    .active    (t_active),
    .edge_ev   (t_edge),
    .rise_ev   (t_rise),
    .last_ev   (t_last),
    .done      (t_done)
  );

  spim_select_timer i_sel_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go),
    .done  (t_done),
    .cs_n  (cs_n)
  );

  spim_shifter i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (go),
    .load_word (load_word),
    .cpha      (cfg_q.cpha),
    .edge_ev   (t_edge),
    .rise_ev   (t_rise),
    .last_ev   (t_last),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_raw)
  );

  assign tx_empty = empty_q;
  assign rx_full  = full_q;
  assign rd_data  = rdat_q;

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tx_empty,
  input logic rd_en,
  input logic rx_full,
  input logic sck,
  input logic cs_n,
  input logic mosi
);

  p_sck_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  p_mosi_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);

  p_write_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_empty) |=> !tx_empty);

  p_select_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> tx_empty);

  p_full_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $rose(cs_n));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_full) |=> (!rx_full || $rose(cs_n)));

endmodule

bind spim_master spim_checker i_chk (.*);

// File: tb/test_spim_master.sv
`timescale 1ns/1ps
module test_spim_master;

  localparam logic [15:0] DUMMY = 16'hA5C3;
  localparam int NVEC = 8;
  // {cpha, lsb, wide, dummy, tx[15:0], slave[15:0]}
  localparam logic [35:0] VEC [0:NVEC-1] = '{
    36'h0_77A5_003C, 36'h4_0013_00C1, 36'h8_0096_005A, 36'hC_0071_0088,
    36'h2_BEEF_1234, 36'hE_8001_7E02, 36'h7_0000_F00D, 36'h9_0000_0042
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_dummy = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic cfg_cpha = 1'b0, cfg_lsb = 1'b0, cfg_wide = 1'b0;
  logic div_wr_en = 1'b0;
  logic [7:0] div_wr_data = '0;
  logic miso_r = 1'b0;
  logic tx_empty, rx_full, sck, cs_n, mosi;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spim_master i_spim_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_dummy(wr_dummy),
    .tx_empty(tx_empty), .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full),
    .cfg_cpha(cfg_cpha), .cfg_lsb(cfg_lsb), .cfg_wide(cfg_wide),
    .div_wr_en(div_wr_en), .div_wr_data(div_wr_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso_r)
  );

  function automatic logic [15:0] wire_of(input logic [15:0] v, input int n, input logic lsb);
    logic [15:0] m, r;
    m = (n == 16) ? v : (v & 16'h00FF);
    r = '0;
    for (int i = 0; i < n; i++) r[i] = m[n-1-i];
    return lsb ? r : m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slave model and serial monitor, all at negedges.
  logic s_cpha = 0, s_lsb = 0;
  int   s_n = 8;
  logic [15:0] s_word = '0, s_wire = '0;
  int   s_idx = 0;
  logic prev_sck = 0, prev_cs = 1, prev_mosi = 0;
  logic [15:0] mon_word = '0;
  int   mon_bits = 0, cs_low = 0;
  logic [15:0] cap_wire [0:31];
  int   cap_bits [0:31];
  int   cap_len  [0:31];
  int   cap_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sck = 0; prev_cs = 1; prev_mosi = 0;
    end else begin
      if (prev_cs && !cs_n) begin
        s_wire = wire_of(s_word, s_n, s_lsb);
        s_idx = 0; mon_word = '0; mon_bits = 0; cs_low = 0;
        if (!s_cpha) begin miso_r = s_wire[s_n-1]; s_idx = 1; end
      end
      if (!cs_n) cs_low++;
      if (!prev_sck && sck) begin
        if (!s_cpha) begin mon_word = {mon_word[14:0], prev_mosi}; mon_bits++; end
        else if (s_idx < s_n) begin miso_r = s_wire[s_n-1-s_idx]; s_idx++; end
      end
      if (prev_sck && !sck) begin
        if (s_cpha) begin mon_word = {mon_word[14:0], prev_mosi}; mon_bits++; end
        else if (s_idx < s_n) begin miso_r = s_wire[s_n-1-s_idx]; s_idx++; end
        else miso_r = 1'b0;
      end
      if (!prev_cs && cs_n && cap_cnt < 32) begin
        cap_wire[cap_cnt] = mon_word; cap_bits[cap_cnt] = mon_bits;
        cap_len[cap_cnt] = cs_low; cap_cnt++;
      end
      prev_mosi = mosi; prev_sck = sck; prev_cs = cs_n;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic frame(input logic cpha, input logic lsb, input logic wide, input logic dmy,
                       input logic [15:0] tx, input logic [15:0] sl, input int d, input string tag);
    int n, base;
    logic [15:0] src;
    n = wide ? 16 : 8;
    base = cap_cnt;
    @(negedge clk);
    cfg_cpha = cpha; cfg_lsb = lsb; cfg_wide = wide;
    s_cpha = cpha; s_lsb = lsb; s_n = n; s_word = sl;
    wr_en = 1; wr_data = tx; wr_dummy = dmy;
    @(negedge clk);
    wr_en = 0; wr_dummy = 0;
    while (cap_cnt == base) @(negedge clk);
    src = dmy ? DUMMY : tx;
    check({tag, " R5 R6 R7 R8 R9 serial word"}, cap_wire[base], wire_of(src, n, lsb));
    check({tag, " R7 bit count"}, cap_bits[base], n);
    check({tag, " R3 R4 select length"}, cap_len[base], (2*n+2)*d);
    check({tag, " R10 rx_full set"}, rx_full, 1);
    check({tag, " R7 R8 R10 received word"}, rd_data, wide ? sl : (sl & 16'h00FF));
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    check({tag, " R10 read clears"}, rx_full, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 cs_n", cs_n, 1);
    check("R1 sck", sck, 0);
    check("R1 mosi", mosi, 0);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_full", rx_full, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 hand-off timing, at the reset divider (R1: D=10).
    cfg_cpha = 0; cfg_lsb = 0; cfg_wide = 0;
    s_cpha = 0; s_lsb = 0; s_n = 8; s_word = 16'h00C3;
    base = cap_cnt;
    wr_en = 1; wr_data = 16'h005A;
    @(negedge clk);
    wr_en = 0;
    check("R2 holding full after write", tx_empty, 0);
    check("R2 select idle before load", cs_n, 1);
    @(negedge clk);
    check("R2 holding empties on load", tx_empty, 1);
    check("R2 select falls on load", cs_n, 0);
    check("R5 first bit before first edge", mosi, 0);
    while (cap_cnt == base) @(negedge clk);
    check("R1 R3 default divider length", cap_len[base], 180);
    check("R5 default frame word", cap_wire[base], 16'h005A);
    check("R10 default frame rx", rd_data, 16'h00C3);
    rd_en = 1; @(negedge clk); rd_en = 0;

    // R4: new divider, D=2.
    div_wr_en = 1; div_wr_data = 8'd1;
    @(negedge clk);
    div_wr_en = 0;

    for (int k = 0; k < NVEC; k++) begin
      frame(VEC[k][35], VEC[k][34], VEC[k][33], VEC[k][32], VEC[k][31:16], VEC[k][15:0], 2,
            $sformatf("vec%0d", k));
    end

    check("R12 idle sck", sck, 0);
    check("R12 idle mosi", mosi, 0);
    check("R12 idle cs_n", cs_n, 1);

    // R11 and R10 overwrite: frame A running, B held, C dropped.
    @(negedge clk);
    cfg_cpha = 0; cfg_lsb = 0; cfg_wide = 0;
    s_cpha = 0; s_lsb = 0; s_n = 8; s_word = 16'h0021;
    base = cap_cnt;
    wr_en = 1; wr_data = 16'h0011;
    @(negedge clk);
    wr_en = 0;
    while (cs_n) @(negedge clk);
    s_word = 16'h0044;
    wr_en = 1; wr_data = 16'h0022;
    @(negedge clk);
    check("R11 second word held", tx_empty, 0);
    wr_data = 16'h0033;
    @(negedge clk);
    wr_en = 0;
    while (cap_cnt < base + 2) @(negedge clk);
    check("R11 first frame word", cap_wire[base], 16'h0011);
    check("R11 held word survives dropped write", cap_wire[base+1], 16'h0022);
    check("R10 overwrite keeps latest", rd_data, 16'h0044);
    check("R10 flag stays set", rx_full, 1);
    repeat (60) @(negedge clk);
    check("R11 no extra frame", cap_cnt, base + 2);
    check("R11 holding empty at end", tx_empty, 1);
    rd_en = 1; @(negedge clk); rd_en = 0;
    check("R10 cleared after read", rx_full, 0);

    finish_run();
  end

endmodule